// File: doc/BRIEF.md
# External Interrupt Priority Arbiter

This block gathers every external interruption condition that can reach one processor and, each time the processor polls it, hands over exactly one of them: the most urgent condition that is both pending and enabled. Conditions that arrive as pulses are held in pending latches. These are the console key, the external call, the interval timer, the service signal, and one bit for each sending processor for malfunction alerts and emergency signals. Two level conditions are evaluated fresh on every poll: a time-of-day value compared against a comparator register, and the sign of a processor timer.

A poll that wins produces a one-cycle `deliver` strobe in the following cycle. The strobe comes with a 16-bit interruption code, the address of the sending processor where the class has one, and the 32-bit service parameter when the winner is the service signal. Only the delivered condition is consumed. Everything else stays pending, so back-to-back polls drain the pending set one condition at a time in priority order.

Top module: `ext_irq_arbiter`

## Requirements
- R1: The fixed order, highest first, and the code each source delivers on `intCode`:
  - console key 0x0040
  - malfunction alert 0x1200
  - emergency signal 0x1201
  - external call 0x1202
  - clock comparator 0x1004
  - processor timer 0x1005
  - interval timer 0x0080
  - service signal 0x2401
- R2: A poll at clock edge N delivers at most one condition. `deliver` is high for one cycle after edge N. While `deliver` is low, `intCode`, `srcCpu` and `servParam` are zero. Undelivered conditions stay pending for later polls.
- R3: For malfunction alerts and emergency signals, the lowest-numbered processor whose bit is set is served and only that bit is cleared. The class stays pending while any other sender bit remains set.
- R4: `srcCpu` carries the served processor number for malfunction alert and emergency signal, and the latched `callSrc` for external call. It is zero for every other code.
- R5: The clock-comparator condition holds while `todValue` is strictly greater than `cmpValue` in an unsigned compare. It is a level condition and delivery does not clear it.
- R6: The processor-timer condition holds while `cpuTimer`, read as signed, is negative. It is a level condition and delivery does not clear it.
- R7: Pulses on `keyReq`, `callReq`, `intvReq` and `servReq` are latched without a poll. Delivering the condition clears its latch, so it is not delivered again.
- R8: `srcEnable` bit k gates source k, numbered in R1 order from bit 0 (console key) to bit 7 (service signal). A disabled source is skipped but stays pending. No delivery happens unless `extEnable` is high in the poll cycle.
- R9: On a service-signal delivery, `servParam` shows the parameter latched with the latest `servReq`. The parameter latch is then zeroed. For every other code `servParam` is zero.
- R10: Request inputs that are high in the poll cycle take part in that poll's arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extEnable | input | 1 | Master external-interrupt enable |
| srcEnable | input | 8 | Per-source enable, bit 0 console key to bit 7 service signal |
| poll | input | 1 | Request to deliver one interrupt |
| keyReq | input | 1 | Console key pulse |
| malfReq | input | NCPU | Malfunction alert pulse per sending processor |
| emerReq | input | NCPU | Emergency signal pulse per sending processor |
| callReq | input | 1 | External call pulse |
| callSrc | input | ADDR_W | Address of the external call sender |
| todValue | input | TOD_W | Time-of-day value |
| cmpValue | input | TOD_W | Clock comparator value |
| cpuTimer | input | TOD_W | Processor timer, signed |
| intvReq | input | 1 | Interval timer pulse |
| servReq | input | 1 | Service signal pulse |
| servParamIn | input | PARM_W | Service signal parameter |
| deliver | output | 1 | One-cycle delivery strobe |
| intCode | output | 16 | Interruption code |
| srcCpu | output | ADDR_W | Originating processor address |
| servParam | output | PARM_W | Delivered service parameter |

## Verification
The first stimulus makes every source pending in a single poll cycle, which exercises same-cycle sampling. Repeated polls then drain the sources, showing the full priority order, the lowest-first draining of several senders in one class, and the level sources being delivered again and again. A per-source mask with one bit clear distinguishes skipping a source from dropping it. Edge values for the comparator (equal, and a top-bit value that a signed compare would misorder) and for the timer (zero versus a sign-bit value) separate strict from non-strict compares and signed from unsigned ones. A poll with the master enable low shows that pending state survives it.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NSRC = 8;

  localparam int SRC_KEY  = 0;
  localparam int SRC_MALF = 1;
  localparam int SRC_EMER = 2;
  localparam int SRC_CALL = 3;
  localparam int SRC_CLKC = 4;
  localparam int SRC_TMR  = 5;
  localparam int SRC_INTV = 6;
  localparam int SRC_SERV = 7;

  localparam logic [15:0] CODE_KEY  = 16'h0040;
  localparam logic [15:0] CODE_MALF = 16'h1200;
  localparam logic [15:0] CODE_EMER = 16'h1201;
  localparam logic [15:0] CODE_CALL = 16'h1202;
  localparam logic [15:0] CODE_CLKC = 16'h1004;
  localparam logic [15:0] CODE_TMR  = 16'h1005;
  localparam logic [15:0] CODE_INTV = 16'h0080;
  localparam logic [15:0] CODE_SERV = 16'h2401;

  // Strobes from control to datapath
  typedef struct packed {
    logic            fire;
    logic [NSRC-1:0] grant;
  } arb_strb_t;

  function automatic logic [15:0] srcCode(input int k);
    case (k)
      SRC_KEY:  return CODE_KEY;
      SRC_MALF: return CODE_MALF;
      SRC_EMER: return CODE_EMER;
      SRC_CALL: return CODE_CALL;
      SRC_CLKC: return CODE_CLKC;
      SRC_TMR:  return CODE_TMR;
      SRC_INTV: return CODE_INTV;
      default:  return CODE_SERV;
    endcase
  endfunction
endpackage

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
(
  input  logic            poll,
  input  logic            extEnable,
  input  logic [NSRC-1:0] srcEnable,
  input  logic [NSRC-1:0] pendVec,
  output arb_strb_t       strb
);
  logic [NSRC-1:0] cand;

  assign cand = pendVec & srcEnable & {NSRC{poll & extEnable}};

  // Fixed priority: lower index wins
  assign strb.grant[0] = cand[0];
  generate
    for (genvar k = 1; k < NSRC; k++) begin : g_prio
      assign strb.grant[k] = cand[k] & ~(|cand[k-1:0]);
    end
  endgenerate

  assign strb.fire = |cand;
endmodule

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int NCPU   = 8,
  parameter int ADDR_W = 16,
  parameter int TOD_W  = 64,
  parameter int PARM_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  arb_strb_t         strb,
  input  logic              keyReq,
  input  logic [NCPU-1:0]   malfReq,
  input  logic [NCPU-1:0]   emerReq,
  input  logic              callReq,
  input  logic [ADDR_W-1:0] callSrc,
  input  logic [TOD_W-1:0]  todValue,
  input  logic [TOD_W-1:0]  cmpValue,
  input  logic [TOD_W-1:0]  cpuTimer,
  input  logic              intvReq,
  input  logic              servReq,
  input  logic [PARM_W-1:0] servParamIn,
  output logic [NSRC-1:0]   pendVec,
  output logic              deliver,
  output logic [15:0]       intCode,
  output logic [ADDR_W-1:0] srcCpu,
  output logic [PARM_W-1:0] servParam
);
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1;

  logic              keyLat, callLat, intvLat, servLat;
  logic [NCPU-1:0]   malfBits, emerBits;
  logic [ADDR_W-1:0] callSrcLat;
  logic [PARM_W-1:0] servParamLat;

  logic              effKey, effCall, effIntv, effServ, cmpHit, tmrNeg;
  logic [NCPU-1:0]   effMalf, effEmer, malfClr, emerClr;
  logic [ADDR_W-1:0] effCallSrc;
  logic [PARM_W-1:0] effParam;
  logic [CPU_W-1:0]  malfIdx, emerIdx;
  logic [15:0]       codeNext;
  logic [ADDR_W-1:0] cpuNext;

  assign effKey     = keyLat | keyReq;
  assign effCall    = callLat | callReq;
  assign effIntv    = intvLat | intvReq;
  assign effServ    = servLat | servReq;
  assign effMalf    = malfBits | malfReq;
  assign effEmer    = emerBits | emerReq;
  assign effCallSrc = callReq ? callSrc : callSrcLat;
  assign effParam   = servReq ? servParamIn : servParamLat;
  assign cmpHit     = todValue > cmpValue;
  assign tmrNeg     = $signed(cpuTimer) < 0;

  // Lowest-numbered sender per class
  always_comb begin
    malfIdx = '0;
    emerIdx = '0;
    for (int i = NCPU - 1; i >= 0; i--) begin
      if (effMalf[i]) malfIdx = CPU_W'(i);
      if (effEmer[i]) emerIdx = CPU_W'(i);
    end
  end

  assign pendVec = {effServ, effIntv, tmrNeg, cmpHit,
                    effCall, |effEmer, |effMalf, effKey};

  assign malfClr = strb.grant[SRC_MALF] ? (NCPU'(1) << malfIdx) : '0;
  assign emerClr = strb.grant[SRC_EMER] ? (NCPU'(1) << emerIdx) : '0;

  always_comb begin
    codeNext = '0;
    for (int k = 0; k < NSRC; k++)
      if (strb.grant[k]) codeNext = codeNext | srcCode(k);
  end

  always_comb begin
    cpuNext = '0;
    if (strb.grant[SRC_MALF])      cpuNext = ADDR_W'(malfIdx);
    else if (strb.grant[SRC_EMER]) cpuNext = ADDR_W'(emerIdx);
    else if (strb.grant[SRC_CALL]) cpuNext = effCallSrc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyLat       <= 1'b0;
      callLat      <= 1'b0;
      intvLat      <= 1'b0;
      servLat      <= 1'b0;
      malfBits     <= '0;
      emerBits     <= '0;
      callSrcLat   <= '0;
      servParamLat <= '0;
      deliver      <= 1'b0;
      intCode      <= '0;
      srcCpu       <= '0;
      servParam    <= '0;
    end else begin
      keyLat       <= effKey  & ~strb.grant[SRC_KEY];
      callLat      <= effCall & ~strb.grant[SRC_CALL];
      intvLat      <= effIntv & ~strb.grant[SRC_INTV];
      servLat      <= effServ & ~strb.grant[SRC_SERV];
      malfBits     <= effMalf & ~malfClr;
      emerBits     <= effEmer & ~emerClr;
      callSrcLat   <= effCallSrc;
      servParamLat <= strb.grant[SRC_SERV] ? '0 : effParam;
      deliver      <= strb.fire;
      intCode      <= codeNext;
      srcCpu       <= cpuNext;
      servParam    <= strb.grant[SRC_SERV] ? effParam : '0;
    end
  end

  // R3: the served malfunction sender bit is gone after the edge
  a_r3_malf_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.grant[SRC_MALF] |=> !malfBits[$past(malfIdx)]);

  // R7: a delivered console key does not stay latched
  a_r7_key_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.grant[SRC_KEY] |=> !keyLat);
endmodule

// File: rtl/ext_irq_arbiter.sv
module ext_irq_arbiter
  import ext_irq_pkg::*;
#(
  parameter int NCPU   = 8,
  parameter int ADDR_W = 16,
  parameter int TOD_W  = 64,
  parameter int PARM_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extEnable,
  input  logic [7:0]        srcEnable,
  input  logic              poll,
  input  logic              keyReq,
  input  logic [NCPU-1:0]   malfReq,
  input  logic [NCPU-1:0]   emerReq,
  input  logic              callReq,
  input  logic [ADDR_W-1:0] callSrc,
  input  logic [TOD_W-1:0]  todValue,
  input  logic [TOD_W-1:0]  cmpValue,
  input  logic [TOD_W-1:0]  cpuTimer,
  input  logic              intvReq,
  input  logic              servReq,
  input  logic [PARM_W-1:0] servParamIn,
  output logic              deliver,
  output logic [15:0]       intCode,
  output logic [ADDR_W-1:0] srcCpu,
  output logic [PARM_W-1:0] servParam
);
  arb_strb_t       strb;
  logic [NSRC-1:0] pendVec;

  ext_irq_ctrl u_ctrl (
    .poll(poll), .extEnable(extEnable), .srcEnable(srcEnable),
    .pendVec(pendVec), .strb(strb)
  );

  ext_irq_datapath #(
    .NCPU(NCPU), .ADDR_W(ADDR_W), .TOD_W(TOD_W), .PARM_W(PARM_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .keyReq(keyReq), .malfReq(malfReq), .emerReq(emerReq),
    .callReq(callReq), .callSrc(callSrc),
    .todValue(todValue), .cmpValue(cmpValue), .cpuTimer(cpuTimer),
    .intvReq(intvReq), .servReq(servReq), .servParamIn(servParamIn),
    .pendVec(pendVec), .deliver(deliver), .intCode(intCode),
    .srcCpu(srcCpu), .servParam(servParam)
  );

  // R8: no delivery without a poll under the master enable
  a_r8_master_gate: assert property (@(posedge clk) disable iff (!rstN)
    deliver |-> $past(poll && extEnable));

  // R4: sender field only for the three signalling classes
  a_r4_sender_zero: assert property (@(posedge clk) disable iff (!rstN)
    (deliver && intCode != CODE_MALF && intCode != CODE_EMER
     && intCode != CODE_CALL) |-> srcCpu == '0);

  // R9: parameter only with the service code
  a_r9_param_zero: assert property (@(posedge clk) disable iff (!rstN)
    (deliver && intCode != CODE_SERV) |-> servParam == '0);

  // R2: outputs quiet between deliveries
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !deliver |-> (intCode == '0 && srcCpu == '0 && servParam == '0));
endmodule

// File: tb/tb_ext_irq_arbiter.sv
`timescale 1ns/1ps
module tb_ext_irq_arbiter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extEnable = 1'b1;
  logic [7:0]  srcEnable = 8'hFF;
  logic        poll = 1'b0;
  logic        keyReq = 1'b0;
  logic [7:0]  malfReq = '0;
  logic [7:0]  emerReq = '0;
  logic        callReq = 1'b0;
  logic [15:0] callSrc = '0;
  logic [63:0] todValue = 64'd100;
  logic [63:0] cmpValue = 64'd100;
  logic [63:0] cpuTimer = 64'd5;
  logic        intvReq = 1'b0;
  logic        servReq = 1'b0;
  logic [31:0] servParamIn = '0;
  logic        deliver;
  logic [15:0] intCode;
  logic [15:0] srcCpu;
  logic [31:0] servParam;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_arbiter dut (
    .clk(clk), .rstN(rstN), .extEnable(extEnable), .srcEnable(srcEnable),
    .poll(poll), .keyReq(keyReq), .malfReq(malfReq), .emerReq(emerReq),
    .callReq(callReq), .callSrc(callSrc), .todValue(todValue),
    .cmpValue(cmpValue), .cpuTimer(cpuTimer), .intvReq(intvReq),
    .servReq(servReq), .servParamIn(servParamIn), .deliver(deliver),
    .intCode(intCode), .srcCpu(srcCpu), .servParam(servParam)
  );

  typedef struct packed {
    logic        keyR;
    logic [7:0]  malf;
    logic [7:0]  emer;
    logic        callR;
    logic [15:0] cSrc;
    logic        cmpHit;
    logic        tmrNeg;
    logic        intvR;
    logic        servR;
    logic [31:0] parm;
    logic [7:0]  en;
    logic        expDel;
    logic [15:0] expCode;
    logic [15:0] expCpu;
    logic [31:0] expParm;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h24, 8'h01, 1'b1, 16'h0033, 1'b1, 1'b1, 1'b1, 1'b1, 32'hCAFE0001, 8'hFF, 1'b1, 16'h0040, 16'h0000, 32'h0},
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 8'hFF, 1'b1, 16'h1200, 16'h0002, 32'h0},
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 8'hFF, 1'b1, 16'h1200, 16'h0005, 32'h0},
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 8'hFF, 1'b1, 16'h1201, 16'h0000, 32'h0},
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 8'hFF, 1'b1, 16'h1202, 16'h0033, 32'h0},
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 8'hFF, 1'b1, 16'h1004, 16'h0000, 32'h0},
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 8'hFF, 1'b1, 16'h1004, 16'h0000, 32'h0},
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 8'hFF, 1'b1, 16'h1005, 16'h0000, 32'h0},
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 8'hFF, 1'b1, 16'h0080, 16'h0000, 32'h0},
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 8'hFF, 1'b1, 16'h2401, 16'h0000, 32'hCAFE0001},
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 8'hFF, 1'b0, 16'h0000, 16'h0000, 32'h0},
    '{1'b1, 8'h80, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 8'hFE, 1'b1, 16'h1200, 16'h0007, 32'h0},
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 8'hFF, 1'b1, 16'h0040, 16'h0000, 32'h0},
    '{1'b0, 8'h00, 8'h0C, 1'b1, 16'h0105, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 8'hFF, 1'b1, 16'h1201, 16'h0002, 32'h0},
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 8'hFF, 1'b1, 16'h1201, 16'h0003, 32'h0},
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 8'hFF, 1'b1, 16'h1202, 16'h0105, 32'h0},
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 8'hFF, 1'b0, 16'h0000, 16'h0000, 32'h0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Poll once with current inputs, then sample after the edge
  task automatic pollOnce();
    poll = 1'b1;
    @(posedge clk);
    @(negedge clk);
    poll = 1'b0;
    keyReq = 1'b0; malfReq = '0; emerReq = '0; callReq = 1'b0;
    intvReq = 1'b0; servReq = 1'b0;
  endtask

  task automatic expectOut(input string tag, input logic d, input logic [15:0] c,
                           input logic [15:0] s, input logic [31:0] p);
    chk({tag, " deliver"}, 64'(deliver), 64'(d));
    chk({tag, " code"}, 64'(intCode), 64'(c));
    chk({tag, " cpu"}, 64'(srcCpu), 64'(s));
    chk({tag, " parm"}, 64'(servParam), 64'(p));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectOut("R2 reset state", 1'b0, 16'h0, 16'h0, 32'h0);

    // Vector walk: R1 R2 R3 R4 R5 R6 R7 R9 R10
    for (int v = 0; v < NV; v++) begin
      keyReq = VECS[v].keyR; malfReq = VECS[v].malf; emerReq = VECS[v].emer;
      callReq = VECS[v].callR; callSrc = VECS[v].cSrc;
      todValue = VECS[v].cmpHit ? 64'd101 : 64'd100;
      cmpValue = 64'd100;
      cpuTimer = VECS[v].tmrNeg ? -64'sd5 : 64'd5;
      intvReq = VECS[v].intvR; servReq = VECS[v].servR;
      servParamIn = VECS[v].parm; srcEnable = VECS[v].en;
      pollOnce();
      expectOut($sformatf("R1/R2/R3/R4/R7/R9/R10 vec %0d", v),
                VECS[v].expDel, VECS[v].expCode, VECS[v].expCpu, VECS[v].expParm);
    end
    todValue = 64'd100; cmpValue = 64'd100; cpuTimer = 64'd5; srcEnable = 8'hFF;

    // R8: master enable low keeps the key pending
    extEnable = 1'b0; keyReq = 1'b1;
    pollOnce();
    expectOut("R8 master off", 1'b0, 16'h0, 16'h0, 32'h0);
    extEnable = 1'b1;
    pollOnce();
    expectOut("R8 master on", 1'b1, 16'h0040, 16'h0, 32'h0);

    // R8: per-source mask skips interval timer without losing it
    intvReq = 1'b1; srcEnable = 8'hBF;
    pollOnce();
    expectOut("R8 intv masked", 1'b0, 16'h0, 16'h0, 32'h0);
    srcEnable = 8'hFF;
    pollOnce();
    expectOut("R8 intv unmasked", 1'b1, 16'h0080, 16'h0, 32'h0);

    // R5: equal is not a hit; unsigned compare at the top bit
    todValue = 64'd77; cmpValue = 64'd77;
    pollOnce();
    expectOut("R5 equal", 1'b0, 16'h0, 16'h0, 32'h0);
    todValue = 64'h8000_0000_0000_0000; cmpValue = 64'd1;
    pollOnce();
    expectOut("R5 unsigned", 1'b1, 16'h1004, 16'h0, 32'h0);
    todValue = 64'd0;

    // R6: zero is not negative; sign bit alone is
    cpuTimer = 64'd0;
    pollOnce();
    expectOut("R6 zero", 1'b0, 16'h0, 16'h0, 32'h0);
    cpuTimer = 64'h8000_0000_0000_0000;
    pollOnce();
    expectOut("R6 negative", 1'b1, 16'h1005, 16'h0, 32'h0);
    cpuTimer = 64'd5;

    // R9: second service delivery carries its own new parameter
    servReq = 1'b1; servParamIn = 32'h1234_5678;
    @(negedge clk);
    servReq = 1'b0; servParamIn = 32'hFFFF_FFFF;
    pollOnce();
    expectOut("R9 latched parm", 1'b1, 16'h2401, 16'h0, 32'h1234_5678);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule